// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block exposes a bank of general-purpose pins to a simple word-addressed register bus. Software drives pins through an output latch that can be replaced whole, or changed bit by bit through a write-one-to-set register and a write-one-to-clear register. Those two registers let several agents touch different pins without a read-modify-write sequence. A direction register decides, pin by pin, whether the pad driver is enabled. A build-time option selects whether a 1 in that register means "output" or means "input".

The register width is a parameter (8, 16, 32 or 64) and equals the pin count. A second build-time option reverses pin numbering, so that pin n is carried by register bit WIDTH-1-n in every register. Incoming pad levels pass through a two-flop synchronizer before software can read them. Read data is registered and appears one cycle after the read strobe.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: The parameter WIDTH must be 8, 16, 32 or 64, and the block has exactly WIDTH pins on each of pad_in, pad_out and pad_oe.
- R2: A write to word 0 (data) loads the whole output latch from wdata. A latch bit of 1 drives its pin high on pad_out, and a 0 drives it low.
- R3: A write to word 1 (set) raises the latch bits written as 1 and leaves the bits written as 0 unchanged.
- R4: A write to word 2 (clear) lowers the latch bits written as 1 and leaves the bits written as 0 unchanged.
- R5: With DIR_IN_POL=0, a direction bit of 1 enables that pin's output (pad_oe high) and a 0 makes the pin an input.
- R6: With DIR_IN_POL=1, a direction bit of 1 makes that pin an input and a 0 enables its output. A write to word 3 loads the direction register.
- R7: With REVERSE=1, pin n corresponds to bit WIDTH-1-n of every register (data readback, set, clear, latch and direction). With REVERSE=0, pin n corresponds to bit n.
- R8: A read of word 0 returns the pad_in levels after a two-flop synchronizer. A pad change is therefore visible to a read whose strobe comes at least two cycles after the change.
- R9: A read of word 1 returns the current output latch value in register bit order.
- R10: A read of word 3 returns the direction register exactly as it was written. A read of word 2 returns zero.
- R11: After reset the latch is all zeros and every pin is an input: pad_out and pad_oe are all zeros. The direction register reads all zeros when DIR_IN_POL=0 and all ones when DIR_IN_POL=1.
- R12: rdata changes only on the clock edge that samples rd_en high, and then holds that value until the next read.
- R13: When a read and a write fall in the same cycle, the read returns the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Word offset: 0 data, 1 set, 2 clear, 3 direction |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Registered read data, one cycle after rd_en |
| pad_in | input | WIDTH | Asynchronous pin levels from the pads |
| pad_out | output | WIDTH | Output level per pin |
| pad_oe | output | WIDTH | Output enable per pin, 1 drives the pad |

## Verification
Two bus operations can fall in the same cycle: a write that changes the latch or the direction register, and a read of the same or another word. The bench raises both strobes on one edge, for example a data write together with a set-register read. It expects rdata to hold the value from before the write, and it expects pad_out to show the new value on the next cycle. Two instances run the same sweeps of every 8-bit value. One has normal order and output polarity. The other has reversed order and input polarity. Each expected value is derived from a bit-reversal and inversion model kept in the bench.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        SEL_LEVEL = 2'd0,
        SEL_RAISE = 2'd1,
        SEL_LOWER = 2'd2,
        SEL_DIR   = 2'd3
    } gpio_sel_e;

    typedef struct packed {
        logic      wr;
        logic      rd;
        gpio_sel_e sel;
    } gpio_cmd_t;

    function automatic bit width_ok(input int w);
        return (w == 8) || (w == 16) || (w == 32) || (w == 64);
    endfunction

endpackage

// File: rtl/gpio_bit_order.sv
module gpio_bit_order #(
    parameter int W       = 8,
    parameter bit REVERSE = 1'b0
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int TOP = W - 1;

    for (genvar i = 0; i < W; i++) begin : g_lane
        if (REVERSE) begin : g_rev
            assign dout[i] = din[TOP-i];
        end else begin : g_fwd
            assign dout[i] = din[i];
        end
    end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= d;
            stable_q <= meta_q;
        end
    end

    assign q = stable_q;

    // R8: the second stage follows the first with one cycle of delay
    p_stage_follow_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stable_q == $past(meta_q));
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_pkg::*;
#(
    parameter int W          = 8,
    parameter bit DIR_IN_POL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  gpio_sel_e    sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] drive_en
);
    localparam logic [W-1:0] DIR_RESET = DIR_IN_POL ? {W{1'b1}} : {W{1'b0}};

    logic [W-1:0] latch_nxt;

    always_comb begin
        latch_nxt = latch_q;
        if (wr) begin
            unique case (sel)
                SEL_LEVEL: latch_nxt = wdata;
                SEL_RAISE: latch_nxt = latch_q | wdata;
                SEL_LOWER: latch_nxt = latch_q & ~wdata;
                default:   latch_nxt = latch_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= DIR_RESET;
        end else begin
            latch_q <= latch_nxt;
            if (wr && sel == SEL_DIR) begin
                dir_q <= wdata;
            end
        end
    end

    if (DIR_IN_POL) begin : g_in_pol
        assign drive_en = ~dir_q;
    end else begin : g_out_pol
        assign drive_en = dir_q;
    end

    p_level_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_LEVEL) |=> latch_q == $past(wdata));

    p_raise_ones_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_RAISE) |=>
            ((latch_q & $past(wdata)) == $past(wdata)) &&
            ((latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata))));

    p_lower_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_LOWER) |=>
            ((latch_q & $past(wdata)) == '0) &&
            ((latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata))));

    // R5 / R6: direction changes only through a direction write
    p_dir_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr && sel == SEL_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter bit DIR_IN_POL = 1'b0,
    parameter bit REVERSE    = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    gpio_cmd_t        cmd;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] drive_en;
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] pins_reg;
    logic [WIDTH-1:0] rdata_q;

    initial begin
        p_width_ok_r1: assert (width_ok(WIDTH))
            else $error("WIDTH %0d not supported", WIDTH);
    end

    assign cmd.wr  = wr_en;
    assign cmd.rd  = rd_en;
    assign cmd.sel = gpio_sel_e'(addr);

    gpio_out_regs #(.W(WIDTH), .DIR_IN_POL(DIR_IN_POL)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr       (cmd.wr),
        .sel      (cmd.sel),
        .wdata    (wdata),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .drive_en (drive_en)
    );

    gpio_bit_order #(.W(WIDTH), .REVERSE(REVERSE)) ord_out_i (
        .din  (latch_q),
        .dout (pad_out)
    );

    gpio_bit_order #(.W(WIDTH), .REVERSE(REVERSE)) ord_oe_i (
        .din  (drive_en),
        .dout (pad_oe)
    );

    gpio_sync2 #(.W(WIDTH)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pins_sync)
    );

    gpio_bit_order #(.W(WIDTH), .REVERSE(REVERSE)) ord_in_i (
        .din  (pins_sync),
        .dout (pins_reg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (cmd.rd) begin
            unique case (cmd.sel)
                SEL_LEVEL: rdata_q <= pins_reg;
                SEL_RAISE: rdata_q <= latch_q;
                SEL_LOWER: rdata_q <= '0;
                SEL_DIR:   rdata_q <= dir_q;
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign rdata = rdata_q;

    p_reset_inputs_r11: assert property (@(posedge clk)
        rst |=> (pad_oe == '0) && (pad_out == '0));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    p_latch_read_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd1) |=> rdata == $past(latch_q));

    p_level_read_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd0) |=> rdata == $past(pins_reg));

    p_lower_read_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd2) |=> rdata == '0);
endmodule

// File: tb/mmio_gpio_ctrl_tb_top.sv
`timescale 1ns/100ps
module mmio_gpio_ctrl_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] pin_a = '0;
    logic [W-1:0] pin_b = '0;
    logic [W-1:0] rd_a, rd_b, out_a, out_b, oe_a, oe_b;

    int n_tests = 0;
    int n_fail  = 0;

    logic [W-1:0] ma_latch, ma_dir, mb_latch, mb_dir;

    always #2.5 clk = ~clk;

    // normal order, output polarity
    mmio_gpio_ctrl #(.WIDTH(W), .DIR_IN_POL(1'b0), .REVERSE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rd_a), .pad_in(pin_a), .pad_out(out_a),
        .pad_oe(oe_a));

    // reversed order, input polarity
    mmio_gpio_ctrl #(.WIDTH(W), .DIR_IN_POL(1'b1), .REVERSE(1'b1)) dut_rev_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rd_b), .pad_in(pin_b), .pad_out(out_b),
        .pad_oe(oe_b));

    function automatic logic [W-1:0] flip(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            2'd0: begin ma_latch = d; mb_latch = d; end
            2'd1: begin ma_latch |= d; mb_latch |= d; end
            2'd2: begin ma_latch &= ~d; mb_latch &= ~d; end
            default: begin ma_dir = d; mb_dir = d; end
        endcase
    endtask

    task automatic bus_read(input logic [1:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_pads(input string req);
        chk({req, " out_a"}, out_a, ma_latch);
        chk({req, " out_b"}, out_b, flip(mb_latch));
        chk({req, " oe_a"},  oe_a,  ma_dir);
        chk({req, " oe_b"},  oe_b,  flip(~mb_dir));
    endtask

    initial begin
        logic [W-1:0] old_a;
        ma_latch = '0; mb_latch = '0; ma_dir = '0; mb_dir = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        chk_pads("R11");
        bus_read(2'd3);
        chk("R11 dir_a", rd_a, 8'h00);
        chk("R11 dir_b", rd_b, 8'hFF);
        bus_read(2'd1);
        chk("R11 latch_a", rd_a, 8'h00);

        // R1 pin count
        chk("R1 pins", W'($bits(out_a)), W'(W));

        // R2 and R9: full data sweep with readback
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd0, W'(v));
            chk_pads("R2");
            bus_read(2'd1);
            chk("R9 a", rd_a, ma_latch);
            chk("R9 b", rd_b, mb_latch);
        end

        // R3 / R4 / R7: set and clear sweeps on a mixed base
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd0, 8'h5A);
            bus_write(2'd1, W'(v));
            chk_pads("R3 R7");
            bus_write(2'd2, W'(v ^ 8'h33));
            chk_pads("R4 R7");
        end

        // R5 / R6 / R10 direction sweep
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd3, W'(v));
            chk_pads("R5 R6");
            bus_read(2'd3);
            chk("R10 dir_a", rd_a, W'(v));
            chk("R10 dir_b", rd_b, W'(v));
        end
        bus_read(2'd2);
        chk("R10 clear reads zero", rd_a, 8'h00);

        // R8 pad readback through synchronizer, R7 order
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            pin_a = W'(v); pin_b = W'(v);
            @(negedge clk);
            bus_read(2'd0);
            chk("R8 a", rd_a, W'(v));
            chk("R8 R7 b", rd_b, flip(W'(v)));
        end
        // R8 too early: strobe one cycle after change sees old level
        @(negedge clk);
        pin_a = 8'hC3;
        rd_en = 1'b1; addr = 2'd0;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R8 not yet synced", rd_a, 8'hFF);

        // R12 hold without read
        bus_write(2'd0, 8'h96);
        chk("R12 hold", rd_a, 8'hFF);
        repeat (3) @(negedge clk);
        chk("R12 hold later", rd_a, 8'hFF);

        // R13 same-cycle write and read
        for (int v = 0; v < 16; v++) begin
            old_a = ma_latch;
            @(negedge clk);
            wr_en = 1'b1; rd_en = 1'b1; addr = 2'd1; wdata = W'(v * 17);
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
            ma_latch |= W'(v * 17); mb_latch |= W'(v * 17);
            chk("R13 read old", rd_a, old_a);
            chk_pads("R13 write lands");
            bus_write(2'd0, 8'h00);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule